// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block converts a 32-bit virtual address into a physical address. It walks a two-level page table held in memory. The top ten address bits pick a word in the page directory, and the directory's physical base comes from the `dirbase` input. That word names a second-level table. The next ten bits pick a word in that table, and that word names the 4 KB physical frame. The low twelve bits pass through as the byte offset.

The walker merges the permissions of the two levels so that the stricter value wins, then checks them against the access type and the privilege mode. When an access succeeds on an entry whose accessed flag is clear, it writes that flag back to memory. A write to a page whose dirty flag is clear raises a fault; the walker does not set the flag. A mode input chooses whether the cache-disable flag or the write-through flag drives the single page-attribute output. A one-entry result register keeps the last successful translation. A repeat access to the same page that the stored permissions allow finishes without any memory traffic. With translation switched off, the address passes through unchanged.

The controller has six states:
- IDLE: waits for a request. It goes to DONE on a bypass or a result-register hit, and to READ_DIR otherwise.
- READ_DIR: fetches the directory entry. On acknowledge it goes to READ_PTE, or to FAULT if the entry is not present.
- READ_PTE: fetches the table entry. On acknowledge it goes to FAULT on any violation, to WRITE_A if the accessed flag is clear, and to DONE otherwise.
- WRITE_A: writes the table entry back with the accessed flag set. On acknowledge it goes to DONE.
- DONE and FAULT: each lasts one cycle, then returns to IDLE.

Top module: `page_walker`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `fault` and `mem_req` are all 0.
- R2: The physical result is {table entry bits 31:12, virtual bits 11:0}. The directory word is read at {dirbase[31:12], va[31:22], 2'b00}. The table word is read at {directory entry bits 31:12, va[21:12], 2'b00}.
- R3: The entry flag bits are: bit 0 present, bit 1 writable, bit 2 user, bit 3 write-through, bit 4 cache-disable, bit 5 accessed, bit 6 dirty. A clear present bit at either level gives fault code 0 (not present).
- R4: The effective user and writable flags are the AND of both levels. The effective cache-disable and write-through flags are the OR of both levels.
- R5: A user-mode access to a page whose effective user flag is clear gives fault code 1 (privilege).
- R6: A write to a page whose effective writable flag is clear gives fault code 2 (write protect). This applies in user mode always, and in supervisor mode only when `wp_en` is 1.
- R7: A write to a page whose table-entry dirty flag is clear gives fault code 3 (dirty). The fault checks apply in this priority order: not present, privilege, write protect, dirty.
- R8: When a walk succeeds on a table entry whose accessed flag is clear, exactly one memory write stores that entry with bit 5 set. No other case writes memory.
- R9: `page_attr` equals the effective write-through flag when `attr_sel` is 1, and the effective cache-disable flag when it is 0.
- R10: With `xlate_en` at 0, `paddr` equals `req_vaddr`, `page_attr` is 0, and no memory access occurs.
- R11: A request finishes with no memory access only when all of the following hold: it hits the result register (same page number and same `dirbase`), and the stored permissions allow the access. Any other request walks memory again.
- R12: With `mem_ack` returned in the cycle of the request, `done` or `fault` appears after the following number of cycles:
  - 1 for a bypass or a hit
  - 2 for a directory not-present fault
  - 3 for any other outcome of the table read
  - 4 when the accessed write-back occurs
- R13: `done` and `fault` are one-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request, taken while idle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| dirbase | input | 32 | Directory base; bits 31:12 used |
| xlate_en | input | 1 | 0 = pass addresses through |
| wp_en | input | 1 | Enforce write protection in supervisor mode |
| attr_sel | input | 1 | 1 = write-through to page_attr, 0 = cache-disable |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 0 not present, 1 privilege, 2 write protect, 3 dirty |
| paddr | output | 32 | Physical address of the last success |
| page_attr | output | 1 | Selected page attribute of the last success |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench sweeps every combination of several inputs:
- the present, user and writable flags at both levels;
- the table entry's dirty, accessed, cache-disable and write-through flags;
- the mode, access type, write-protect control and attribute select.

Each combination uses a distinct page, so the walk is always exercised. The result tells the fault priority apart, separates supervisor from user writes under `wp_en`, and shows whether the accessed write-back occurs through the memory word and the latency.

Directed patterns cover the remaining cases. A repeated read after a table change proves that a hit uses the stored frame with no memory traffic. A write to a stored clean page proves that a denied hit walks again. A bypass request confirms pass-through with no memory activity.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int unsigned BIT_P  = 0;
    localparam int unsigned BIT_W  = 1;
    localparam int unsigned BIT_U  = 2;
    localparam int unsigned BIT_WT = 3;
    localparam int unsigned BIT_CD = 4;
    localparam int unsigned BIT_A  = 5;
    localparam int unsigned BIT_D  = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ_DIR, ST_READ_PTE, ST_WRITE_A, ST_DONE, ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        FC_NOT_PRESENT = 2'd0,
        FC_PRIV        = 2'd1,
        FC_WRPROT      = 2'd2,
        FC_DIRTY       = 2'd3
    } fault_code_t;

    typedef struct packed {
        logic usr;
        logic wr;
        logic cd;
        logic wt;
    } perm_t;
endpackage

// File: rtl/pw_perm_merge.sv
module pw_perm_merge
    import pw_pkg::*;
(
    input  perm_t dir_p,
    input  perm_t tbl_p,
    output perm_t eff_p
);
    // Grants need both levels; cache restrictions need either level.
    always_comb begin
        eff_p.usr = dir_p.usr & tbl_p.usr;
        eff_p.wr  = dir_p.wr  & tbl_p.wr;
        eff_p.cd  = dir_p.cd  | tbl_p.cd;
        eff_p.wt  = dir_p.wt  | tbl_p.wt;
    end
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check
    import pw_pkg::*;
(
    input  logic        usr_ok,
    input  logic        wr_ok,
    input  logic        dirty,
    input  logic        is_user,
    input  logic        is_write,
    input  logic        wp_en,
    output logic        ok,
    output fault_code_t code
);
    logic priv_bad, wp_bad, dirty_bad;

    always_comb begin
        priv_bad  = is_user && !usr_ok;
        wp_bad    = is_write && !wr_ok && (is_user || wp_en);
        dirty_bad = is_write && !dirty;
        ok        = !(priv_bad || wp_bad || dirty_bad);
        if (priv_bad)    code = FC_PRIV;
        else if (wp_bad) code = FC_WRPROT;
        else             code = FC_DIRTY;
    end

    always_comb begin
        if (ok) begin
            assert_user_blocked_R5: assert (!is_user || usr_ok);
            assert_write_guard_R6: assert (!is_write || wr_ok || (!is_user && !wp_en));
        end
    end
endmodule

// File: rtl/pw_attr_mux.sv
module pw_attr_mux (
    input  logic cd,
    input  logic wt,
    input  logic sel,
    output logic attr
);
    assign attr = sel ? wt : cd;
endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic            req_user,
    input  logic [VA_W-1:0] dirbase,
    input  logic            xlate_en,
    input  logic            wp_en,
    input  logic            attr_sel,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic [1:0]      fault_code,
    output logic [VA_W-1:0] paddr,
    output logic            page_attr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [VA_W-1:0] mem_addr,
    output logic [VA_W-1:0] mem_wdata,
    input  logic [VA_W-1:0] mem_rdata,
    input  logic            mem_ack
);
    localparam int unsigned FRAME_W = VA_W - OFF_W;
    localparam int unsigned IDX_W   = FRAME_W / 2;
    localparam int unsigned PAD_W   = OFF_W - IDX_W;

    walk_state_t state, state_n;

    logic [VA_W-1:0]    vaddr_q;
    logic               write_q, user_q, wp_q, sel_q;
    logic [FRAME_W-1:0] base_q, dir_frame_q;
    perm_t              dir_perm_q;
    logic [VA_W-1:0]    pte_q;
    logic [VA_W-1:0]    paddr_q;
    logic               attr_q;
    fault_code_t        fcode_q;

    logic               c_valid;
    logic [FRAME_W-1:0] c_vpn, c_base, c_frame;
    perm_t              c_perm;
    logic               c_dirty;

    logic [OFF_W-1:0]   unused_dirbase_low;
    assign unused_dirbase_low = dirbase[OFF_W-1:0];

    // Hit path: stored permissions against the live request.
    logic        hit_ok, hit, hit_attr;
    fault_code_t hit_code;
    pw_perm_check u_hit_chk (
        .usr_ok(c_perm.usr), .wr_ok(c_perm.wr), .dirty(c_dirty),
        .is_user(req_user), .is_write(req_write), .wp_en(wp_en),
        .ok(hit_ok), .code(hit_code)
    );
    pw_attr_mux u_hit_attr (.cd(c_perm.cd), .wt(c_perm.wt), .sel(attr_sel), .attr(hit_attr));
    assign hit = c_valid && hit_ok
              && (c_vpn == req_vaddr[VA_W-1:OFF_W])
              && (c_base == dirbase[VA_W-1:OFF_W]);

    // Walk path: directory flags merged with the incoming table entry.
    perm_t       tbl_perm, eff_perm;
    logic        walk_ok, walk_attr;
    fault_code_t walk_code;
    assign tbl_perm = '{usr: mem_rdata[BIT_U], wr: mem_rdata[BIT_W],
                        cd: mem_rdata[BIT_CD], wt: mem_rdata[BIT_WT]};
    pw_perm_merge u_merge (.dir_p(dir_perm_q), .tbl_p(tbl_perm), .eff_p(eff_perm));
    pw_perm_check u_walk_chk (
        .usr_ok(eff_perm.usr), .wr_ok(eff_perm.wr), .dirty(mem_rdata[BIT_D]),
        .is_user(user_q), .is_write(write_q), .wp_en(wp_q),
        .ok(walk_ok), .code(walk_code)
    );
    pw_attr_mux u_walk_attr (.cd(eff_perm.cd), .wt(eff_perm.wt), .sel(sel_q), .attr(walk_attr));

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_n = (!xlate_en || hit) ? ST_DONE : ST_READ_DIR;
            ST_READ_DIR: if (mem_ack) state_n = mem_rdata[BIT_P] ? ST_READ_PTE : ST_FAULT;
            ST_READ_PTE: if (mem_ack) begin
                             if (!mem_rdata[BIT_P] || !walk_ok) state_n = ST_FAULT;
                             else if (!mem_rdata[BIT_A])        state_n = ST_WRITE_A;
                             else                               state_n = ST_DONE;
                         end
            ST_WRITE_A:  if (mem_ack) state_n = ST_DONE;
            ST_DONE:     state_n = ST_IDLE;
            ST_FAULT:    state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q <= '0; write_q <= 1'b0; user_q <= 1'b0; wp_q <= 1'b0; sel_q <= 1'b0;
            base_q <= '0; dir_frame_q <= '0; dir_perm_q <= '0; pte_q <= '0;
            paddr_q <= '0; attr_q <= 1'b0; fcode_q <= FC_NOT_PRESENT;
            c_valid <= 1'b0; c_vpn <= '0; c_base <= '0; c_frame <= '0;
            c_perm <= '0; c_dirty <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr; write_q <= req_write; user_q <= req_user;
                    wp_q <= wp_en; sel_q <= attr_sel; base_q <= dirbase[VA_W-1:OFF_W];
                    if (!xlate_en) begin
                        paddr_q <= req_vaddr;
                        attr_q  <= 1'b0;
                    end else if (hit) begin
                        paddr_q <= {c_frame, req_vaddr[OFF_W-1:0]};
                        attr_q  <= hit_attr;
                    end
                end
                ST_READ_DIR: if (mem_ack) begin
                    dir_frame_q <= mem_rdata[VA_W-1:OFF_W];
                    dir_perm_q  <= tbl_perm;
                    if (!mem_rdata[BIT_P]) fcode_q <= FC_NOT_PRESENT;
                end
                ST_READ_PTE: if (mem_ack) begin
                    pte_q <= mem_rdata;
                    if (!mem_rdata[BIT_P]) begin
                        fcode_q <= FC_NOT_PRESENT;
                    end else if (!walk_ok) begin
                        fcode_q <= walk_code;
                    end else begin
                        paddr_q <= {mem_rdata[VA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
                        attr_q  <= walk_attr;
                        c_valid <= 1'b1;
                        c_vpn   <= vaddr_q[VA_W-1:OFF_W];
                        c_base  <= base_q;
                        c_frame <= mem_rdata[VA_W-1:OFF_W];
                        c_perm  <= eff_perm;
                        c_dirty <= mem_rdata[BIT_D];
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        fault     = (state == ST_FAULT);
        mem_req   = (state == ST_READ_DIR) || (state == ST_READ_PTE) || (state == ST_WRITE_A);
        mem_we    = (state == ST_WRITE_A);
        mem_wdata = pte_q | (VA_W'(1) << BIT_A);
        if (state == ST_READ_DIR)
            mem_addr = {base_q, vaddr_q[VA_W-1 -: IDX_W], {PAD_W{1'b0}}};
        else
            mem_addr = {dir_frame_q, vaddr_q[OFF_W+IDX_W-1:OFF_W], {PAD_W{1'b0}}};
    end
    assign fault_code = fcode_q;
    assign paddr      = paddr_q;
    assign page_attr  = attr_q;

    assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault));
    assert_done_one_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    assert_fault_one_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !fault);
    assert_we_sets_accessed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && mem_wdata[BIT_A]));
    assert_no_mem_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !mem_req);
endmodule

// File: tb/page_walker_test.sv
`timescale 1ns/1ps
module page_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_vaddr = '0, dirbase = '0;
    logic        xlate_en = 1'b1, wp_en = 1'b0, attr_sel = 1'b0;
    logic        busy, done, fault, page_attr, mem_req, mem_we, mem_ack;
    logic [1:0]  fault_code;
    logic [31:0] paddr, mem_addr, mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    page_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .dirbase(dirbase),
        .xlate_en(xlate_en), .wp_en(wp_en), .attr_sel(attr_sel),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .paddr(paddr), .page_attr(page_attr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Memory model: page 0 holds directories, page 1 holds tables.
    logic [31:0] mem [0:2047];
    int          mem_cycles = 0;
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[12:2]];
    always @(posedge clk) begin
        if (mem_req) mem_cycles <= mem_cycles + 1;
        if (mem_req && mem_we) mem[mem_addr[12:2]] <= mem_wdata;
    end

    int n_chk = 0, n_fail = 0;
    int lat;
    logic got_done, got_fault, got_attr;
    logic [1:0] got_code;
    logic [31:0] got_pa;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_xlate(input logic [31:0] va, input logic w, input logic u);
        @(negedge clk);
        req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && !fault && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        got_done = done; got_fault = fault; got_code = fault_code;
        got_pa = paddr; got_attr = page_attr;
        if (lat >= 40) chk(1'b0, "R12 no completion", lat, 0);
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    logic [12:0] b;
    logic [9:0]  didx, tidx;
    logic [19:0] frame;
    logic [11:0] off;
    logic        eU, eW, ecd, ewt, dcd, dwt;
    int          exp_out, act_out, exp_lat, mc0;
    logic [31:0] te, exp_te;

    initial begin
        for (int k = 0; k < 2048; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1 reset idle",
            {busy, done, fault, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);

        // Sweep: every combination of flags, mode, access and controls, each on its own page.
        for (int i = 0; i < 8192; i++) begin
            b     = i[12:0];
            didx  = 10'(3 + i / 1024);
            tidx  = 10'(i % 1024);
            frame = 20'(i + 256);
            off   = 12'(i * 7 + 5);
            dcd   = b[5] & b[6];
            dwt   = b[7] & b[8];
            mem[didx] = {20'd1, 5'd0, 1'b0, 1'b1, dcd, dwt, b[1], b[2], b[0]};
            te = {frame, 3'b101, 2'b00, b[6], b[7], b[11], b[12], b[4], b[5], b[3]};
            mem[1024 + tidx] = te;
            wp_en    = b[10];
            attr_sel = b[1] ^ b[9];
            eU  = b[1] & b[4];
            eW  = b[2] & b[5];
            ecd = dcd | b[11];
            ewt = dwt | b[12];
            exp_te = te;
            if (!b[0])                                   begin exp_out = 0; exp_lat = 2; end
            else if (!b[3])                              begin exp_out = 0; exp_lat = 3; end
            else if (b[8] && !eU)                        begin exp_out = 1; exp_lat = 3; end
            else if (b[9] && !eW && (b[8] || b[10]))     begin exp_out = 2; exp_lat = 3; end
            else if (b[9] && !b[6])                      begin exp_out = 3; exp_lat = 3; end
            else begin
                exp_out = 4;
                exp_lat = b[7] ? 3 : 4;
                exp_te  = te | 32'h20;
            end
            run_xlate({didx, tidx, off}, b[9], b[8]);
            act_out = got_done ? 4 : (got_fault ? int'(got_code) : 9);
            chk(act_out == exp_out,
                exp_out == 0 ? "R3 not present" : exp_out == 1 ? "R5 privilege" :
                exp_out == 2 ? "R6 write protect" : exp_out == 3 ? "R7 dirty" : "R4 success",
                act_out, exp_out);
            chk(lat == exp_lat, "R12 latency", lat, exp_lat);
            chk(mem[1024 + tidx] == exp_te, "R8 accessed write-back", mem[1024 + tidx], exp_te);
            if (exp_out == 4) begin
                chk(got_pa == {frame, off}, "R2 physical address", got_pa, {frame, off});
                chk(got_attr == (attr_sel ? ewt : ecd), "R9 attribute select",
                    got_attr, attr_sel ? ewt : ecd);
            end
        end

        // R13: pulse lasts one cycle.
        @(negedge clk);
        chk(!done && !fault, "R13 single pulse", {done, fault}, 0);

        // R10: bypass.
        xlate_en = 1'b0;
        mc0 = mem_cycles;
        run_xlate(32'hDEADBEEF, 1'b1, 1'b1);
        chk(got_done && got_pa == 32'hDEADBEEF, "R10 bypass address", got_pa, 32'hDEADBEEF);
        chk(!got_attr && lat == 1, "R10 bypass attr/latency", {got_attr, lat[7:0]}, 1);
        chk(mem_cycles == mc0, "R10 no memory", mem_cycles, mc0);
        xlate_en = 1'b1;

        // R11: hit uses stored result with no memory access.
        wp_en = 1'b0; attr_sel = 1'b0;
        mem[40]   = 32'h0000_1027;
        mem[1031] = 32'h0077_7067;
        run_xlate({10'd40, 10'd7, 12'h123}, 1'b0, 1'b1);
        chk(got_done && lat == 3 && got_pa == 32'h0077_7123, "R11 first walk", got_pa, 32'h0077_7123);
        mem[1031] = 32'h0088_8067;
        mc0 = mem_cycles;
        run_xlate({10'd40, 10'd7, 12'h456}, 1'b0, 1'b1);
        chk(got_done && got_pa == 32'h0077_7456, "R11 hit keeps frame", got_pa, 32'h0077_7456);
        chk(lat == 1 && mem_cycles == mc0, "R11 hit no memory", mem_cycles - mc0, 0);

        // R11: denied hit walks again (clean page written).
        mem[1032] = 32'h0099_9027;
        run_xlate({10'd40, 10'd8, 12'h010}, 1'b0, 1'b0);
        chk(got_done && got_pa == 32'h0099_9010, "R11 clean page read", got_pa, 32'h0099_9010);
        mc0 = mem_cycles;
        run_xlate({10'd40, 10'd8, 12'h010}, 1'b1, 1'b0);
        chk(got_fault && got_code == 2'd3, "R7 dirty after hit", got_code, 3);
        chk(lat == 3 && mem_cycles == mc0 + 2, "R11 denied hit rewalks", mem_cycles - mc0, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule